// File: doc/BRIEF.md
# Analog Window Watchdog

This block sits beside an analog-to-digital converter's sequencer and watches the stream of conversion results. Each result arrives with the number of the channel it came from. When the watchdog is enabled, every result it is asked to watch is compared against a programmable 12-bit window. A result strictly above the upper limit or strictly below the lower limit sets a sticky alarm flag. The flag, masked by an interrupt-enable bit, drives an interrupt line.

The watchdog can watch every channel or only one selected channel. A built-in periodic trigger generator lets software sample the watched channel at a fixed interval instead of converting continuously. A prescaler divides the clock down to a one-millisecond tick, and a 16-bit reload value sets how many ticks pass between trigger pulses. Software programs the block through a small word-addressed register port with single-cycle writes and a combinational read path.

Top module: `win_watch`

## Requirements
- R1: After a synchronous reset all registers read as zero, and irq_o and trig_o are low.
- R2: The limits register (address 1) holds the upper limit in bits 27:16 and the lower limit in bits 11:0. All its other bits read back as zero.
- R3: With the enable bit (bit 23 of the control register, address 0) set, a result strictly greater than the upper limit or strictly less than the lower limit sets the alarm flag. The flag becomes visible on the clock edge that captures the result. A result equal to either limit leaves the flag unchanged.
- R4: When bit 22 of the control register is set, only results whose channel equals the 5-bit field at bits 30:26 are compared. When bit 22 is clear, results from every channel are compared against the same window. Only bits 30:26, 23, 22 and 10 of the control register are stored; all others read as zero.
- R5: While the enable bit is clear, no result sets the flag, and a flag that is already set is kept.
- R6: The flag is bit 7 of the status register (address 2). It stays set while later results fall inside the window. Writing 1 to bit 7 clears it, and writing 0 has no effect. If an out-of-window result and a clearing write arrive in the same cycle, the flag ends up set.
- R7: irq_o is high exactly when the flag is set and bit 7 of the interrupt-mask register (address 3) is set.
- R8: With bit 10 of the control register set, trig_o gives a one-cycle pulse every (reload+1)*CLK_PER_MS clock cycles, where reload is bits 15:0 of the interval register (address 4). With bit 10 clear, trig_o stays low and the counters restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| smp_valid | input | 1 | A conversion result is present this cycle |
| smp_chan | input | 5 | Channel number of the result |
| smp_data | input | 12 | Conversion result |
| irq_o | output | 1 | Masked watchdog interrupt |
| trig_o | output | 1 | Periodic conversion trigger pulse |

## Verification
The hardest case to reach is an out-of-window result and a flag-clearing write landing in the very same clock cycle. Only there does the priority between hardware set and software clear show. The bench has a dedicated driver task that raises the sample strobe and the write strobe on the same falling edge. It then checks that the flag survives. Channel filtering is exercised with a deliberately out-of-window result on a non-selected channel, so that only the channel match can suppress the alarm.

// File: rtl/win_watch_pkg.sv
`timescale 1ns/1ps
package win_watch_pkg;

    localparam int SMP_W  = 12;
    localparam int CHAN_W = 5;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int IVL_W  = 16;

    // control register field positions
    localparam int CTL_SEL_LSB = 26;
    localparam int CTL_EN_BIT  = 23;
    localparam int CTL_ONE_BIT = 22;
    localparam int CTL_TRG_BIT = 10;
    // limits register field positions
    localparam int LIM_HI_LSB  = 16;
    localparam int LIM_LO_LSB  = 0;
    // status / mask bit
    localparam int ALARM_BIT   = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTL  = 3'd0,
        RA_LIM  = 3'd1,
        RA_STAT = 3'd2,
        RA_MASK = 3'd3,
        RA_IVL  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [CHAN_W-1:0] sel;
        logic              en;
        logic              one_chan;
        logic              trig_en;
    } ctl_t;

    typedef struct packed {
        logic [SMP_W-1:0] hi;
        logic [SMP_W-1:0] lo;
    } limits_t;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic [SMP_W-1:0]  data;
    } sample_t;

    function automatic logic outside_window(input logic [SMP_W-1:0] v,
                                            input limits_t lim);
        return (v > lim.hi) || (v < lim.lo);
    endfunction

    function automatic logic chan_selected(input ctl_t c,
                                           input logic [CHAN_W-1:0] ch);
        return !c.one_chan || (ch == c.sel);
    endfunction

endpackage

// File: rtl/win_watch_cmp.sv
module win_watch_cmp
    import win_watch_pkg::*;
(
    input  sample_t smp,
    input  ctl_t    ctl,
    input  limits_t lim,
    output logic    hit
);
    logic watched;
    logic beyond;

    always_comb begin
        watched = smp.valid && ctl.en && chan_selected(ctl, smp.chan);
        beyond  = outside_window(smp.data, lim);
        hit     = watched && beyond;
    end
endmodule

// File: rtl/win_watch_trig.sv
module win_watch_trig #(
    parameter int CLK_PER_MS = 48000,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] reload,
    output logic             trig
);
    localparam int PSC_W = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(CLK_PER_MS - 1);

    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick = (psc == PSC_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            psc  <= '0;
            cnt  <= '0;
            trig <= 1'b0;
        end else begin
            trig <= 1'b0;
            if (tick) begin
                psc <= '0;
                if (cnt == reload) begin
                    cnt  <= '0;
                    trig <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end else begin
                psc <= psc + PSC_W'(1);
            end
        end
    end

    // R8
    trig_gated_chk: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(en));

    // R8 (pulse width, CLK_PER_MS of 2 or more)
    trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);
endmodule

// File: rtl/win_watch_regs.sv
module win_watch_regs
    import win_watch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              hit,
    output ctl_t              ctl,
    output limits_t           lim,
    output logic [IVL_W-1:0]  reload,
    output logic              alarm,
    output logic              mask,
    output logic [REG_W-1:0]  rdata
);
    logic clr_req;
    logic unused_wd;

    assign unused_wd = ^wdata;
    assign clr_req   = we && (addr == RA_STAT) && wdata[ALARM_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            lim    <= '0;
            reload <= '0;
            mask   <= 1'b0;
        end else if (we) begin
            case (addr)
                RA_CTL: begin
                    ctl.sel      <= wdata[CTL_SEL_LSB +: CHAN_W];
                    ctl.en       <= wdata[CTL_EN_BIT];
                    ctl.one_chan <= wdata[CTL_ONE_BIT];
                    ctl.trig_en  <= wdata[CTL_TRG_BIT];
                end
                RA_LIM: begin
                    lim.hi <= wdata[LIM_HI_LSB +: SMP_W];
                    lim.lo <= wdata[LIM_LO_LSB +: SMP_W];
                end
                RA_MASK: mask   <= wdata[ALARM_BIT];
                RA_IVL:  reload <= wdata[IVL_W-1:0];
                default: ;
            endcase
        end
    end

    // hardware set wins over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)          alarm <= 1'b0;
        else if (hit)     alarm <= 1'b1;
        else if (clr_req) alarm <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTL: begin
                rdata[CTL_SEL_LSB +: CHAN_W] = ctl.sel;
                rdata[CTL_EN_BIT]            = ctl.en;
                rdata[CTL_ONE_BIT]           = ctl.one_chan;
                rdata[CTL_TRG_BIT]           = ctl.trig_en;
            end
            RA_LIM: begin
                rdata[LIM_HI_LSB +: SMP_W] = lim.hi;
                rdata[LIM_LO_LSB +: SMP_W] = lim.lo;
            end
            RA_STAT: rdata[ALARM_BIT]  = alarm;
            RA_MASK: rdata[ALARM_BIT]  = mask;
            RA_IVL:  rdata[IVL_W-1:0]  = reload;
            default: rdata = '0;
        endcase
    end

    // R6
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm && !clr_req) |=> alarm);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> alarm);
endmodule

// File: rtl/win_watch.sv
module win_watch
    import win_watch_pkg::*;
#(
    parameter int CLK_PER_MS = 48000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              smp_valid,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              irq_o,
    output logic              trig_o
);
    sample_t          smp;
    ctl_t             ctl;
    limits_t          lim;
    logic [IVL_W-1:0] reload;
    logic             alarm;
    logic             mask;
    logic             hit;
    logic             clr_port;

    assign smp      = '{valid: smp_valid, chan: smp_chan, data: smp_data};
    assign clr_port = reg_we && (reg_addr == RA_STAT) && reg_wdata[ALARM_BIT];

    win_watch_cmp u_cmp (
        .smp (smp),
        .ctl (ctl),
        .lim (lim),
        .hit (hit)
    );

    win_watch_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .hit    (hit),
        .ctl    (ctl),
        .lim    (lim),
        .reload (reload),
        .alarm  (alarm),
        .mask   (mask),
        .rdata  (reg_rdata)
    );

    win_watch_trig #(
        .CLK_PER_MS (CLK_PER_MS),
        .CNT_W      (IVL_W)
    ) u_trig (
        .clk    (clk),
        .rst    (rst),
        .en     (ctl.trig_en),
        .reload (reload),
        .trig   (trig_o)
    );

    assign irq_o = alarm && mask;

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !clr_port) |=> $stable(alarm));

    // R3
    in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!alarm && !(smp_valid && ((smp_data > lim.hi) || (smp_data < lim.lo))))
        |=> !alarm);

    // R4
    other_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (!alarm && ctl.one_chan && (smp_chan != ctl.sel)) |=> !alarm);

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (reg_addr != RA_STAT) || reg_rdata[ALARM_BIT]);
endmodule

// File: tb/tb_win_watch.sv
`timescale 1ns/1ps
module tb_win_watch;
    localparam int K = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smp_valid = 1'b0;
    logic [4:0]  smp_chan = '0;
    logic [11:0] smp_data = '0;
    logic        irq_o, trig_o;

    int total = 0;
    int bad   = 0;

    // bench model of programmed state
    bit         m_en, m_one, m_flag, m_mask;
    bit [4:0]   m_sel;
    bit [11:0]  m_hi, m_lo;

    bit    q_flag[$];
    bit    q_irq[$];
    string q_tag[$];

    always #5 clk = ~clk;

    win_watch #(.CLK_PER_MS(K)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
        .smp_chan(smp_chan), .smp_data(smp_data), .irq_o(irq_o), .trig_o(trig_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 3'd2; reg_wdata = '0;
        case (a)
            3'd0: begin m_sel = d[30:26]; m_en = d[23]; m_one = d[22]; end
            3'd1: begin m_hi = d[27:16]; m_lo = d[11:0]; end
            3'd2: if (d[7]) m_flag = 1'b0;
            3'd3: m_mask = d[7];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; #1;
        d = reg_rdata;
        reg_addr = 3'd2;
    endtask

    function automatic bit model_event(input logic [4:0] ch, input logic [11:0] v);
        return m_en && (!m_one || ch == m_sel) && (v > m_hi || v < m_lo);
    endfunction

    // driver: one sample, optionally with a simultaneous clearing write
    task automatic smp(input logic [4:0] ch, input logic [11:0] v,
                       input bit with_clr, input string tag);
        bit ev;
        ev = model_event(ch, v);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = ch; smp_data = v;
        if (with_clr) begin reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h80; end
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0;
        if (ev) m_flag = 1'b1;
        else if (with_clr) m_flag = 1'b0;
        q_flag.push_back(m_flag);
        q_irq.push_back(m_flag && m_mask);
        q_tag.push_back(tag);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // monitor: compares the next expected item as results appear
    always @(negedge clk) begin
        if (q_flag.size() > 0) begin
            bit ef, ei;
            string t;
            ef = q_flag.pop_front();
            ei = q_irq.pop_front();
            t  = q_tag.pop_front();
            chk({t, " flag"}, {31'd0, reg_rdata[7]}, {31'd0, ef});
            chk({t, " irq"}, {31'd0, irq_o}, {31'd0, ei});
        end
    end

    task automatic trig_gap(input int exp_gap, input string tag);
        int n;
        n = 0;
        while (trig_o !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
        n = 0;
        @(negedge clk);
        n = 1;
        while (trig_o !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
        chk(tag, n, exp_gap);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int pulses;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 reg reset", d, 32'h0);
        end
        chk("R1 irq reset", {31'd0, irq_o}, 32'd0);
        chk("R1 trig reset", {31'd0, trig_o}, 32'd0);

        // R2 limits readback, unused bits zero
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d);
        chk("R2 limits mask", d, 32'h0FFF_0FFF);
        wr(3'd1, {4'h0, 12'h800, 4'h0, 12'h100});
        rd(3'd1, d);
        chk("R2 limits fields", d, 32'h0800_0100);

        // R4 control register stored bits
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d);
        chk("R4 ctl mask", d, 32'h7CC0_0400);
        wr(3'd0, 32'h0080_0000);   // enabled, all channels

        // R3 boundaries and out-of-window
        smp(5'd0, 12'h800, 0, "R3 equal high");
        smp(5'd1, 12'h100, 0, "R3 equal low");
        smp(5'd2, 12'h801, 0, "R3 above high");
        // R6 sticky, write 0 ignored, write 1 clears
        smp(5'd2, 12'h400, 0, "R6 sticky inside");
        wr(3'd2, 32'h0);
        rd(3'd2, d);
        chk("R6 write0 no clear", d, 32'h80);
        wr(3'd2, 32'h80);
        rd(3'd2, d);
        chk("R6 write1 clears", d, 32'h0);
        smp(5'd3, 12'h0FF, 0, "R3 below low");
        // R6 same-cycle set wins
        smp(5'd3, 12'hFFF, 1, "R6 set beats clear");
        smp(5'd3, 12'h200, 1, "R6 clear with inside sample");

        // R7 mask
        smp(5'd4, 12'h000, 0, "R7 unmasked flag");
        chk("R7 masked irq", {31'd0, irq_o}, 32'd0);
        wr(3'd3, 32'h80);
        chk("R7 irq on", {31'd0, irq_o}, 32'd1);
        wr(3'd2, 32'h80);
        chk("R7 irq follows clear", {31'd0, irq_o}, 32'd0);

        // R4 single channel mode, channel 3
        wr(3'd0, (32'd3 << 26) | 32'h00C0_0000);
        smp(5'd5, 12'hFFF, 0, "R4 other channel ignored");
        smp(5'd3, 12'hFFF, 0, "R4 selected channel");
        wr(3'd2, 32'h80);
        wr(3'd0, 32'h0080_0000);
        smp(5'd7, 12'h000, 0, "R4 all channels");

        // R5 disabled: existing flag kept, no new flag
        wr(3'd0, 32'h0);
        smp(5'd7, 12'h500, 0, "R5 flag kept");
        wr(3'd2, 32'h80);
        smp(5'd7, 12'hFFF, 0, "R5 no new flag");

        // R8 periodic trigger
        pulses = 0;
        repeat (40) begin @(negedge clk); if (trig_o) pulses++; end
        chk("R8 no pulse when off", pulses, 0);
        wr(3'd4, 32'd2);
        wr(3'd0, 32'h0000_0400);
        trig_gap(3 * K, "R8 gap reload2");
        wr(3'd0, 32'h0);
        wr(3'd4, 32'd0);
        wr(3'd0, 32'h0000_0400);
        trig_gap(K, "R8 gap reload0");
        wr(3'd0, 32'h0);
        pulses = 0;
        repeat (40) begin @(negedge clk); if (trig_o) pulses++; end
        chk("R8 stops when off", pulses, 0);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule